// File: doc/BRIEF.md
# Exception Entry and Vectoring Controller

This block collects exception requests raised elsewhere in a processor core, keeps them as a pending bitmask, and picks one to take. It then runs the entry sequence in a single clock. That sequence saves a return address and a status word, rewrites the machine-state word, and points instruction fetch at the handler for the chosen exception. Each request arrives as a one-cycle set pulse on its own line, together with a small cause code. The core supplies the addresses of the current and next instructions and its live machine-state word. The core reads the saved registers, the new machine state and the handler address whenever the taken pulse is high.

Masking depends on the live machine state. External and decrementer requests wait while interrupts are disabled. A floating-point program request is discarded while floating-point exceptions are turned off. A machine check that arrives while machine checks are disabled stops the controller until reset.

Top module: `exc_vector_unit`

## Requirements
- R1: A set pulse on line i latches pending bit i and its 2-bit cause. Of the pending, unmasked requests, the lowest index is taken. Its entry outputs appear one clock after the pending bit is visible, so for two requests raised together the lower index is taken first and the higher index one clock later.
- R2: While machine-state bit 15 (interrupt enable) is 0, external (index 5) and decrementer (index 9) requests are not taken. They stay pending and are taken once the bit is 1.
- R3: A program request (index 7) with cause 0 (floating point) is discarded without entry while machine-state bits 11 and 8 are both 0. It is not taken later when either bit becomes 1.
- R4: The handler address is the index shifted left by 8. For the reset request (index 1) with machine-state bit 6 set, the high base 0xFFF00000 is added, giving 0xFFF00100.
- R5: The saved return address is the current-instruction address for indices 3, 6, 7 and 8, and the next-instruction address for every other index.
- R6: For index 4, the saved status is the machine state ORed with 0x40000000 for cause 0, with 0x10000000 for causes 1 and 2, and with 0x08000000 for cause 3.
- R7: For index 7, the saved status is the machine state with bits 31..16 cleared, ORed with 0x00010000 and with one further bit: 0x00100000 for cause 0, 0x00080000 for cause 1, 0x00040000 for cause 2, 0x00020000 for cause 3. For all other indices except 4, the saved status equals the machine state.
- R8: On entry, the new machine state is the input with bits 18, 15, 14, 13, 11, 10, 9, 8, 5, 4 and 1 cleared, and with bit 0 loaded from bit 16.
- R9: A machine check (index 2) taken while bit 12 is 1 clears bit 12 in the new machine state. If bit 12 is 0, checkstop is raised and no entry occurs.
- R10: Checkstop is sticky until reset. While it is high, no request is taken.
- R11: Taking a request clears its pending bit. The taken pulse is high for one cycle per entry.
- R12: After reset, all outputs are zero and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setVec | input | 16 | One-cycle request pulse per exception index |
| causeVec | input | 32 | 2-bit cause per index, index i at bits 2i+1..2i |
| curPc | input | 32 | Address of the current instruction |
| nextPc | input | 32 | Address of the next instruction |
| msrIn | input | 32 | Live machine-state word |
| savedPc | output | 32 | Saved return address |
| savedStatus | output | 32 | Saved status word with cause bits |
| newMsr | output | 32 | Machine state to load on entry |
| handlerAddr | output | 32 | Fetch address of the handler |
| takenPulse | output | 1 | High for one cycle per entry |
| checkstop | output | 1 | Sticky stop after a disabled machine check |

## Verification
The bench uses the default build: sixteen request lines, two-bit causes and a high base of 0xFFF00000. With this build, every index with special handling is reachable, along with plain indices above them and every cause code. Masked requests are held through several idle cycles and then released, which shows that they wait rather than vanish. The discarded floating-point request is then shown to stay gone after the mode bits change. The checkstop case runs last, so its stickiness can be observed without another reset.

// File: rtl/exc_pkg.sv
package exc_pkg;
  parameter int EXC_NUM = 16;
  parameter int CAUSE_W = 2;
  parameter int ADDR_W  = 32;
  localparam int IDX_W  = $clog2(EXC_NUM);

  localparam int IDX_RESET = 1;
  localparam int IDX_MCHK  = 2;
  localparam int IDX_DACC  = 3;
  localparam int IDX_IACC  = 4;
  localparam int IDX_EXT   = 5;
  localparam int IDX_ALIGN = 6;
  localparam int IDX_PROG  = 7;
  localparam int IDX_NOFP  = 8;
  localparam int IDX_DEC   = 9;

  localparam int B_LE  = 0;
  localparam int B_RI  = 1;
  localparam int B_DR  = 4;
  localparam int B_IR  = 5;
  localparam int B_IP  = 6;
  localparam int B_FE1 = 8;
  localparam int B_BE  = 9;
  localparam int B_SE  = 10;
  localparam int B_FE0 = 11;
  localparam int B_ME  = 12;
  localparam int B_FP  = 13;
  localparam int B_PR  = 14;
  localparam int B_EE  = 15;
  localparam int B_ILE = 16;
  localparam int B_POW = 18;

  localparam logic [CAUSE_W-1:0] PC_FLOAT = 2'd0;
  localparam logic [CAUSE_W-1:0] PC_ILL   = 2'd1;
  localparam logic [CAUSE_W-1:0] PC_PRIV  = 2'd2;
  localparam logic [CAUSE_W-1:0] PC_TRAP  = 2'd3;

  localparam logic [CAUSE_W-1:0] IC_MISS  = 2'd0;
  localparam logic [CAUSE_W-1:0] IC_NOEX  = 2'd1;
  localparam logic [CAUSE_W-1:0] IC_GUARD = 2'd2;
  localparam logic [CAUSE_W-1:0] IC_PROT  = 2'd3;

  typedef struct packed {
    logic               take;
    logic [IDX_W-1:0]   idx;
    logic [CAUSE_W-1:0] cause;
    logic               useCur;
    logic               clrMe;
    logic               highVec;
  } entryStrobe_t;
endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [EXC_NUM-1:0]         setVec,
  input  logic [EXC_NUM*CAUSE_W-1:0] causeVec,
  input  logic [ADDR_W-1:0]          msrIn,
  output entryStrobe_t               strobe,
  output logic                       checkstop
);
  logic [EXC_NUM-1:0] pend;
  logic [EXC_NUM-1:0] pendClr;
  logic [EXC_NUM-1:0] eligible;
  logic [CAUSE_W-1:0] causeReg [EXC_NUM];
  logic               found;
  logic [IDX_W-1:0]   pick;
  logic               fpDrop;
  logic               stopNow;

  assign fpDrop = pend[IDX_PROG] && (causeReg[IDX_PROG] == PC_FLOAT) &&
                  !(msrIn[B_FE0] || msrIn[B_FE1]);

  generate
    for (genvar g = 0; g < EXC_NUM; g++) begin : g_slot
      if (g == IDX_EXT || g == IDX_DEC) begin : g_ee
        assign eligible[g] = pend[g] && msrIn[B_EE];
      end else if (g == IDX_PROG) begin : g_prog
        assign eligible[g] = pend[g] && !fpDrop;
      end else begin : g_plain
        assign eligible[g] = pend[g];
      end

      always_ff @(posedge clk) begin
        if (!rstN) causeReg[g] <= '0;
        else if (setVec[g]) causeReg[g] <= causeVec[g*CAUSE_W +: CAUSE_W];
      end
    end
  endgenerate

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < EXC_NUM; i++) begin
      if (eligible[i] && !found) begin
        found = 1'b1;
        pick  = IDX_W'(i);
      end
    end
  end

  always_comb begin
    strobe  = '0;
    stopNow = 1'b0;
    pendClr = '0;
    if (!checkstop) begin
      if (fpDrop) pendClr[IDX_PROG] = 1'b1;
      if (found) begin
        if (pick == IDX_W'(IDX_MCHK) && !msrIn[B_ME]) begin
          stopNow = 1'b1;
        end else begin
          strobe.take    = 1'b1;
          strobe.idx     = pick;
          strobe.cause   = causeReg[pick];
          strobe.useCur  = (pick == IDX_W'(IDX_DACC)) || (pick == IDX_W'(IDX_ALIGN)) ||
                           (pick == IDX_W'(IDX_PROG)) || (pick == IDX_W'(IDX_NOFP));
          strobe.clrMe   = (pick == IDX_W'(IDX_MCHK));
          strobe.highVec = (pick == IDX_W'(IDX_RESET)) && msrIn[B_IP];
          pendClr[pick]  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend      <= '0;
      checkstop <= 1'b0;
    end else begin
      pend <= (pend & ~pendClr) | setVec;
      if (stopNow) checkstop <= 1'b1;
    end
  end

  a_r10_stop_sticky: assert property (@(posedge clk) disable iff (!rstN)
    checkstop |=> checkstop);
  a_r10_no_take_stopped: assert property (@(posedge clk) disable iff (!rstN)
    checkstop |-> !strobe.take);
  a_r2_ee_masks: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && !msrIn[B_EE]) |->
      (strobe.idx != IDX_W'(IDX_EXT) && strobe.idx != IDX_W'(IDX_DEC)));
  a_r3_fp_not_taken: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && strobe.idx == IDX_W'(IDX_PROG) && strobe.cause == PC_FLOAT) |->
      (msrIn[B_FE0] || msrIn[B_FE1]));
  a_r11_pend_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && !setVec[strobe.idx]) |=> !pend[$past(strobe.idx)]);
endmodule

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFFF0_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  entryStrobe_t      strobe,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [ADDR_W-1:0] nextPc,
  input  logic [ADDR_W-1:0] msrIn,
  output logic [ADDR_W-1:0] savedPc,
  output logic [ADDR_W-1:0] savedStatus,
  output logic [ADDR_W-1:0] newMsr,
  output logic [ADDR_W-1:0] handlerAddr,
  output logic              takenPulse
);
  localparam int HALF = ADDR_W / 2;

  logic [ADDR_W-1:0] statusNext;
  logic [ADDR_W-1:0] msrNext;
  logic [ADDR_W-1:0] vecNext;

  always_comb begin
    statusNext = msrIn;
    if (strobe.idx == IDX_W'(IDX_IACC)) begin
      case (strobe.cause)
        IC_MISS:           statusNext = msrIn | 32'h4000_0000;
        IC_NOEX, IC_GUARD: statusNext = msrIn | 32'h1000_0000;
        default:           statusNext = msrIn | 32'h0800_0000;
      endcase
    end else if (strobe.idx == IDX_W'(IDX_PROG)) begin
      statusNext = {{HALF{1'b0}}, msrIn[HALF-1:0]} | 32'h0001_0000;
      case (strobe.cause)
        PC_FLOAT: statusNext = statusNext | 32'h0010_0000;
        PC_ILL:   statusNext = statusNext | 32'h0008_0000;
        PC_PRIV:  statusNext = statusNext | 32'h0004_0000;
        default:  statusNext = statusNext | 32'h0002_0000;
      endcase
    end
  end

  always_comb begin
    msrNext        = msrIn;
    msrNext[B_POW] = 1'b0;
    msrNext[B_EE]  = 1'b0;
    msrNext[B_PR]  = 1'b0;
    msrNext[B_FP]  = 1'b0;
    msrNext[B_FE0] = 1'b0;
    msrNext[B_SE]  = 1'b0;
    msrNext[B_BE]  = 1'b0;
    msrNext[B_FE1] = 1'b0;
    msrNext[B_IR]  = 1'b0;
    msrNext[B_DR]  = 1'b0;
    msrNext[B_RI]  = 1'b0;
    msrNext[B_LE]  = msrIn[B_ILE];
    if (strobe.clrMe) msrNext[B_ME] = 1'b0;
  end

  assign vecNext = (ADDR_W'(strobe.idx) << 8) + (strobe.highVec ? HIGH_BASE : '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedPc     <= '0;
      savedStatus <= '0;
      newMsr      <= '0;
      handlerAddr <= '0;
      takenPulse  <= 1'b0;
    end else begin
      takenPulse <= strobe.take;
      if (strobe.take) begin
        savedPc     <= strobe.useCur ? curPc : nextPc;
        savedStatus <= statusNext;
        newMsr      <= msrNext;
        handlerAddr <= vecNext;
      end
    end
  end

  a_r8_state_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> (!newMsr[B_EE] && !newMsr[B_PR] && !newMsr[B_IR] && !newMsr[B_DR]
                     && newMsr[B_LE] == $past(msrIn[B_ILE])));
  a_r5_saved_pc: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && !strobe.useCur) |=> savedPc == $past(nextPc));
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_pkg::*;
#(
  parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFFF0_0000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [EXC_NUM-1:0]         setVec,
  input  logic [EXC_NUM*CAUSE_W-1:0] causeVec,
  input  logic [ADDR_W-1:0]          curPc,
  input  logic [ADDR_W-1:0]          nextPc,
  input  logic [ADDR_W-1:0]          msrIn,
  output logic [ADDR_W-1:0]          savedPc,
  output logic [ADDR_W-1:0]          savedStatus,
  output logic [ADDR_W-1:0]          newMsr,
  output logic [ADDR_W-1:0]          handlerAddr,
  output logic                       takenPulse,
  output logic                       checkstop
);
  entryStrobe_t strobe;

  exc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .setVec(setVec), .causeVec(causeVec),
    .msrIn(msrIn), .strobe(strobe), .checkstop(checkstop)
  );

  exc_datapath #(.HIGH_BASE(HIGH_BASE)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curPc(curPc), .nextPc(nextPc),
    .msrIn(msrIn), .savedPc(savedPc), .savedStatus(savedStatus),
    .newMsr(newMsr), .handlerAddr(handlerAddr), .takenPulse(takenPulse)
  );
endmodule

// File: tb/exc_vector_unit_tb_top.sv
`timescale 1ns/1ps
module exc_vector_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] setVec;
  logic [31:0] causeVec;
  logic [31:0] curPc, nextPc, msrIn;
  logic [31:0] savedPc, savedStatus, newMsr, handlerAddr;
  logic        takenPulse, checkstop;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [31:0] CUR = 32'h1000_0040;
  localparam logic [31:0] NXT = 32'h1000_0044;

  always #2.5 clk = ~clk;

  exc_vector_unit dut_i (
    .clk(clk), .rstN(rstN), .setVec(setVec), .causeVec(causeVec),
    .curPc(curPc), .nextPc(nextPc), .msrIn(msrIn), .savedPc(savedPc),
    .savedStatus(savedStatus), .newMsr(newMsr), .handlerAddr(handlerAddr),
    .takenPulse(takenPulse), .checkstop(checkstop)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expMsr(input logic [31:0] m, input bit mc);
    logic [31:0] r;
    r = m & ~32'h0004_EF32;
    r[0] = m[16];
    if (mc) r[12] = 1'b0;
    return r;
  endfunction

  task automatic fire(input logic [15:0] m, input logic [31:0] c);
    @(negedge clk);
    setVec = m; causeVec = c;
    @(negedge clk);
    setVec = '0; causeVec = '0;
  endtask

  task automatic expectEntry(input string tag, input logic [31:0] vec,
                             input logic [31:0] pc, input logic [31:0] st);
    @(negedge clk);
    chk({tag, " taken"}, {31'b0, takenPulse}, 32'd1);
    chk({tag, " vector"}, handlerAddr, vec);
    chk({tag, " savedPc"}, savedPc, pc);
    chk({tag, " status"}, savedStatus, st);
  endtask

  task automatic expectIdle(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(tag, {31'b0, takenPulse}, 32'd0);
    end
  endtask

  task automatic t_reset;
    chk("R12 savedPc", savedPc, 0);
    chk("R12 status", savedStatus, 0);
    chk("R12 msr", newMsr, 0);
    chk("R12 vector", handlerAddr, 0);
    chk("R12 taken/stop", {30'b0, takenPulse, checkstop}, 0);
  endtask

  task automatic t_priority;
    msrIn = 32'h0000_8000;
    fire(16'h0028, 32'h0);
    expectEntry("R1 first idx3 R5", 32'h300, CUR, msrIn);
    expectEntry("R1 second idx5 R5", 32'h500, NXT, msrIn);
    expectIdle("R11 single pulse", 1);
  endtask

  task automatic t_mask;
    msrIn = 32'h0000_0000;
    fire(16'h0220, 32'h0);
    expectIdle("R2 masked", 3);
    msrIn = 32'h0000_8000;
    expectEntry("R2 ext released", 32'h500, NXT, msrIn);
    expectEntry("R2 dec kept pending", 32'h900, NXT, msrIn);
    expectIdle("R11 pending cleared", 2);
  endtask

  task automatic t_fpdrop;
    logic [31:0] m;
    msrIn = 32'h0000_8000;
    fire(16'h0080, 32'h0);
    expectIdle("R3 fp discarded", 2);
    msrIn = 32'h0000_8800;
    expectIdle("R3 stays discarded", 2);
    m = 32'hA5A5_1934;
    msrIn = m;
    fire(16'h0080, {16'h0, 2'd1, 14'h0});
    expectEntry("R7 illegal", 32'h700, CUR, {16'h0, m[15:0]} | 32'h0009_0000);
  endtask

  task automatic t_isi;
    logic [31:0] m;
    logic [31:0] bits [4];
    bits[0] = 32'h4000_0000; bits[1] = 32'h1000_0000;
    bits[2] = 32'h1000_0000; bits[3] = 32'h0800_0000;
    m = 32'h05A5_1234;
    msrIn = m;
    for (int c = 0; c < 4; c++) begin
      fire(16'h0010, 32'(c) << 8);
      expectEntry($sformatf("R6 cause%0d", c), 32'h400, NXT, m | bits[c]);
    end
  endtask

  task automatic t_prog;
    logic [31:0] m;
    logic [31:0] bits [4];
    bits[0] = 32'h0010_0000; bits[1] = 32'h0008_0000;
    bits[2] = 32'h0004_0000; bits[3] = 32'h0002_0000;
    m = 32'hFFFF_0800;
    msrIn = m;
    for (int c = 0; c < 4; c++) begin
      fire(16'h0080, 32'(c) << 14);
      expectEntry($sformatf("R7 cause%0d", c), 32'h700, CUR,
                  32'h0000_0800 | 32'h0001_0000 | bits[c]);
    end
  endtask

  task automatic t_msr;
    msrIn = 32'hFFFF_FFFF;
    fire(16'h1000, 32'h0);
    expectEntry("R8 all ones idx12", 32'hC00, NXT, 32'hFFFF_FFFF);
    chk("R8 msr ile=1", newMsr, expMsr(32'hFFFF_FFFF, 0));
    msrIn = 32'hFFFE_FFFF;
    fire(16'h0100, 32'h0);
    expectEntry("R8 idx8 R5", 32'h800, CUR, 32'hFFFE_FFFF);
    chk("R8 msr ile=0", newMsr, expMsr(32'hFFFE_FFFF, 0));
  endtask

  task automatic t_resetvec;
    msrIn = 32'h0000_0040;
    fire(16'h0002, 32'h0);
    expectEntry("R4 high", 32'hFFF0_0100, NXT, msrIn);
    msrIn = 32'h0000_0000;
    fire(16'h0002, 32'h0);
    expectEntry("R4 low", 32'h0000_0100, NXT, msrIn);
    msrIn = 32'h0000_8000;
    fire(16'h0040, 32'h0);
    expectEntry("R5 align", 32'h600, CUR, msrIn);
  endtask

  task automatic t_mcheck;
    msrIn = 32'h0000_F000;
    fire(16'h0004, 32'h0);
    expectEntry("R9 enabled", 32'h200, NXT, msrIn);
    chk("R9 me cleared", newMsr, expMsr(32'h0000_F000, 1));
    msrIn = 32'h0000_8000;
    fire(16'h0004, 32'h0);
    @(negedge clk);
    chk("R9 no entry", {31'b0, takenPulse}, 0);
    chk("R9 checkstop", {31'b0, checkstop}, 1);
    fire(16'h0008, 32'h0);
    expectIdle("R10 halted", 3);
    chk("R10 sticky", {31'b0, checkstop}, 1);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rstN = 1'b0; setVec = '0; causeVec = '0;
    curPc = CUR; nextPc = NXT; msrIn = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_priority();
    t_mask();
    t_fpdrop();
    t_isi();
    t_prog();
    t_msr();
    t_resetvec();
    t_mcheck();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule